// File: doc/BRIEF.md
# Bridge Uncorrectable Error Reporter

This block sits on the parallel-bus side of a bridge that converts serial link traffic to parallel bus traffic. It watches for two kinds of uncorrectable data error. The first is a data error found in a split read completion that crosses the bridge. The second is a parity error that the initiating bus master signals while the bridge forwards a read completion that is not already poisoned. Each error event arrives as a one-cycle pulse, together with the header of the transaction involved.

For every error, the block updates three sets of status bits: uncorrectable status, bus status and device status. It captures the transaction header into a four-word log, which a first-error pointer guards. It also drives the parity error pin, a poison mark for the forwarded completion, and fatal or non-fatal message requests toward the link layer. Software programs the enables, masks and severities through a plain word-addressed read/write port, and uses the same port to read and clear status. A status bit is cleared by writing one to it.

Top module: `xerr_reporter`

## Requirements
- R1: After reset, every register reads zero and all four output pins are low.
- R2: A split-completion data error drives `poisonOut` high for exactly the cycle after the event, whatever the enables are. A master parity event never poisons.
- R3: `perrOut` pulses, and bus status bit 0 (master data parity error) is set, only for a split-completion error while control bit 0 (parity response enable) is 1.
- R4: The uncorrectable status register gets bit 0 for a split-completion error and bit 1 for a master parity event, whatever the mask says. A master parity event is ignored when `cplPoisoned` is 1.
- R5: The header is captured into log words 0..3 (word 0 = `evtHdr[31:0]`), and the pointer register is loaded (bit 31 = valid, bit 0 = status bit number), only when that error's mask bit is 0 and the pointer is not valid. Otherwise the log keeps its contents.
- R6: A message is requested only when the error's mask bit is 0 and either control bit 1 (system error enable) is set or the enable for its class is set: control bit 2 for fatal, control bit 3 for non-fatal. Severity bit 1 selects fatal and 0 selects non-fatal.
- R7: Bus status bit 1 (signaled system error) is set when a message is requested while control bit 1 is 1.
- R8: Device status bit 0 (fatal seen) or bit 1 (non-fatal seen) is set according to the error's severity, independent of the mask.
- R9: Status registers are write-one-to-clear. Clearing the status bit that the valid pointer names makes the pointer invalid and re-arms logging. Clearing any other bit leaves the pointer as it is.
- R10: When both errors arrive in the same cycle, status bit 0 wins the pointer. A fatal request suppresses a simultaneous non-fatal one.
- R11: The register map is: 0 control (read/write, bits 3:0), 1 bus status, 2 device status, 3 uncorrectable status, 4 mask (read/write), 5 severity (read/write), 6 pointer (read only), 8..11 header log (read only). Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| splitDataErr | input | 1 | Pulse: data error in a split read completion |
| masterPerr | input | 1 | Pulse: initiating master signalled parity error during completion forwarding |
| cplPoisoned | input | 1 | The completion being forwarded was already poisoned |
| evtHdr | input | 128 | Header of the transaction involved in the event |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 4 | Register word address |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data (combinational) |
| perrOut | output | 1 | Parity error pin request |
| poisonOut | output | 1 | Mark the forwarded completion as poisoned |
| msgFatal | output | 1 | Fatal error message request |
| msgNonFatal | output | 1 | Non-fatal error message request |

## Verification
All four output pins are registered. Each one is due in the single cycle after the event is sampled, and stays low in every other cycle. The driver queues the expected pin pattern, tagged with the cycle count at which it is due. The monitor compares the pins at every falling edge, and expects zeros whenever no entry is due, so stray or late pulses are caught. Status, pointer and log registers settle at the same edge as the event, so the bench reads them back through the combinational port in the very next low phase.

// File: rtl/xerr_pkg.sv
package xerr_pkg;
  localparam int NUM_ERR = 2;
  localparam int IDX_W   = 1;
  localparam int ERR_SPLIT = 0;
  localparam int ERR_MPERR = 1;
  localparam int CFG_AW  = 4;

  localparam logic [CFG_AW-1:0] A_CTRL   = 4'd0;
  localparam logic [CFG_AW-1:0] A_BUSSTS = 4'd1;
  localparam logic [CFG_AW-1:0] A_DEVSTS = 4'd2;
  localparam logic [CFG_AW-1:0] A_UESTS  = 4'd3;
  localparam logic [CFG_AW-1:0] A_UEMASK = 4'd4;
  localparam logic [CFG_AW-1:0] A_UESEV  = 4'd5;
  localparam logic [CFG_AW-1:0] A_PTR    = 4'd6;
  localparam int A_HDR0 = 8;

  localparam int C_PERR = 0;
  localparam int C_SYSERR = 1;
  localparam int C_FATAL = 2;
  localparam int C_NONFATAL = 3;
  localparam int B_MDPE = 0;
  localparam int B_SSE = 1;
  localparam int D_FATAL = 0;
  localparam int D_NONFATAL = 1;

  typedef struct packed {
    logic [NUM_ERR-1:0] setUe;
    logic               logHdr;
    logic [IDX_W-1:0]   logIdx;
    logic               setMdpe;
    logic               setSse;
    logic               setFatal;
    logic               setNonFatal;
    logic               perr;
    logic               poison;
    logic               msgFatal;
    logic               msgNonFatal;
  } strobe_t;
endpackage

// File: rtl/xerr_ctrl.sv
module xerr_ctrl
  import xerr_pkg::*;
(
  input  logic               splitErr,
  input  logic               mstPerr,
  input  logic               cplPoisoned,
  input  logic               perrRespEn,
  input  logic               sysErrEn,
  input  logic               fatalRptEn,
  input  logic               nonFatalRptEn,
  input  logic [NUM_ERR-1:0] ueMask,
  input  logic [NUM_ERR-1:0] ueSev,
  input  logic               ptrFree,
  output strobe_t            stb
);
  logic [NUM_ERR-1:0] evt;
  logic [NUM_ERR-1:0] rptOk;
  logic [NUM_ERR-1:0] elig;
  logic [IDX_W-1:0]   firstIdx;
  logic               anyFatalMsg;

  always_comb begin
    evt = '0;
    evt[ERR_SPLIT] = splitErr;
    evt[ERR_MPERR] = mstPerr && !cplPoisoned;
    for (int i = 0; i < NUM_ERR; i++) begin
      rptOk[i] = sysErrEn || (ueSev[i] ? fatalRptEn : nonFatalRptEn);
      elig[i]  = evt[i] && !ueMask[i];
    end
    firstIdx = '0;
    for (int i = NUM_ERR - 1; i >= 0; i--) begin
      if (elig[i]) firstIdx = IDX_W'(i);
    end
  end

  assign anyFatalMsg = |(elig & rptOk & ueSev);

  always_comb begin
    stb             = '0;
    stb.setUe       = evt;
    stb.logHdr      = (|elig) && ptrFree;
    stb.logIdx      = firstIdx;
    stb.setMdpe     = splitErr && perrRespEn;
    stb.perr        = splitErr && perrRespEn;
    stb.poison      = splitErr;
    stb.msgFatal    = anyFatalMsg;
    stb.msgNonFatal = (|(elig & rptOk & ~ueSev)) && !anyFatalMsg;
    stb.setSse      = (stb.msgFatal || stb.msgNonFatal) && sysErrEn;
    stb.setFatal    = |(evt & ueSev);
    stb.setNonFatal = |(evt & ~ueSev);
  end
endmodule

// File: rtl/xerr_dpath.sv
module xerr_dpath
  import xerr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int HDR_WORDS = 4,
  localparam int HDR_W    = WORD_W * HDR_WORDS
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [HDR_W-1:0]   evtHdr,
  input  logic               cfgWe,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [WORD_W-1:0]  cfgWdata,
  output logic [WORD_W-1:0]  cfgRdata,
  output logic               perrRespEn,
  output logic               sysErrEn,
  output logic               fatalRptEn,
  output logic               nonFatalRptEn,
  output logic [NUM_ERR-1:0] ueMask,
  output logic [NUM_ERR-1:0] ueSev,
  output logic               ptrFree,
  output logic               ptrValid,
  output logic               perrOut,
  output logic               poisonOut,
  output logic               msgFatal,
  output logic               msgNonFatal
);
  logic [3:0]         ctrlReg;
  logic [1:0]         busSts;
  logic [1:0]         devSts;
  logic [NUM_ERR-1:0] ueSts;
  logic [IDX_W-1:0]   ptrIdx;
  logic [WORD_W-1:0]  hdrLog [HDR_WORDS];
  logic [NUM_ERR-1:0] ueClr;
  logic [1:0]         busClr;
  logic [1:0]         devClr;
  logic               unusedWdata;

  assign unusedWdata = ^cfgWdata;

  assign perrRespEn    = ctrlReg[C_PERR];
  assign sysErrEn      = ctrlReg[C_SYSERR];
  assign fatalRptEn    = ctrlReg[C_FATAL];
  assign nonFatalRptEn = ctrlReg[C_NONFATAL];

  assign ueClr  = (cfgWe && cfgAddr == A_UESTS)  ? cfgWdata[NUM_ERR-1:0] : '0;
  assign busClr = (cfgWe && cfgAddr == A_BUSSTS) ? cfgWdata[1:0] : '0;
  assign devClr = (cfgWe && cfgAddr == A_DEVSTS) ? cfgWdata[1:0] : '0;
  assign ptrFree = !ptrValid || ueClr[ptrIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      ueMask  <= '0;
      ueSev   <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == A_CTRL)   ctrlReg <= cfgWdata[3:0];
      if (cfgAddr == A_UEMASK) ueMask  <= cfgWdata[NUM_ERR-1:0];
      if (cfgAddr == A_UESEV)  ueSev   <= cfgWdata[NUM_ERR-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busSts <= '0;
      devSts <= '0;
      ueSts  <= '0;
    end else begin
      ueSts          <= (ueSts & ~ueClr) | stb.setUe;
      busSts[B_MDPE] <= (busSts[B_MDPE] && !busClr[B_MDPE]) || stb.setMdpe;
      busSts[B_SSE]  <= (busSts[B_SSE] && !busClr[B_SSE]) || stb.setSse;
      devSts[D_FATAL]    <= (devSts[D_FATAL] && !devClr[D_FATAL]) || stb.setFatal;
      devSts[D_NONFATAL] <= (devSts[D_NONFATAL] && !devClr[D_NONFATAL]) || stb.setNonFatal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrValid <= 1'b0;
      ptrIdx   <= '0;
    end else if (stb.logHdr) begin
      ptrValid <= 1'b1;
      ptrIdx   <= stb.logIdx;
    end else if (ptrValid && ueClr[ptrIdx]) begin
      ptrValid <= 1'b0;
    end
  end

  for (genvar g = 0; g < HDR_WORDS; g++) begin : g_hdr
    always_ff @(posedge clk) begin
      if (!rstN) hdrLog[g] <= '0;
      else if (stb.logHdr) hdrLog[g] <= evtHdr[g*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perrOut     <= 1'b0;
      poisonOut   <= 1'b0;
      msgFatal    <= 1'b0;
      msgNonFatal <= 1'b0;
    end else begin
      perrOut     <= stb.perr;
      poisonOut   <= stb.poison;
      msgFatal    <= stb.msgFatal;
      msgNonFatal <= stb.msgNonFatal;
    end
  end

  always_comb begin
    cfgRdata = '0;
    case (cfgAddr)
      A_CTRL:   cfgRdata[3:0] = ctrlReg;
      A_BUSSTS: cfgRdata[1:0] = busSts;
      A_DEVSTS: cfgRdata[1:0] = devSts;
      A_UESTS:  cfgRdata[NUM_ERR-1:0] = ueSts;
      A_UEMASK: cfgRdata[NUM_ERR-1:0] = ueMask;
      A_UESEV:  cfgRdata[NUM_ERR-1:0] = ueSev;
      A_PTR: begin
        cfgRdata[IDX_W-1:0] = ptrIdx;
        cfgRdata[WORD_W-1]  = ptrValid;
      end
      default: begin
        for (int w = 0; w < HDR_WORDS; w++) begin
          if (cfgAddr == CFG_AW'(A_HDR0 + w)) cfgRdata = hdrLog[w];
        end
      end
    endcase
  end
endmodule

// File: rtl/xerr_reporter.sv
module xerr_reporter
  import xerr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int HDR_WORDS = 4,
  localparam int HDR_W    = WORD_W * HDR_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              splitDataErr,
  input  logic              masterPerr,
  input  logic              cplPoisoned,
  input  logic [HDR_W-1:0]  evtHdr,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgWdata,
  output logic [WORD_W-1:0] cfgRdata,
  output logic              perrOut,
  output logic              poisonOut,
  output logic              msgFatal,
  output logic              msgNonFatal
);
  strobe_t            stb;
  logic               perrRespEn;
  logic               sysErrEn;
  logic               fatalRptEn;
  logic               nonFatalRptEn;
  logic [NUM_ERR-1:0] ueMask;
  logic [NUM_ERR-1:0] ueSev;
  logic               ptrFree;
  logic               logPtrValid;

  xerr_ctrl u_ctrl (
    .splitErr(splitDataErr), .mstPerr(masterPerr), .cplPoisoned(cplPoisoned),
    .perrRespEn(perrRespEn), .sysErrEn(sysErrEn), .fatalRptEn(fatalRptEn),
    .nonFatalRptEn(nonFatalRptEn), .ueMask(ueMask), .ueSev(ueSev),
    .ptrFree(ptrFree), .stb(stb)
  );

  xerr_dpath #(.WORD_W(WORD_W), .HDR_WORDS(HDR_WORDS)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .evtHdr(evtHdr),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .perrRespEn(perrRespEn), .sysErrEn(sysErrEn), .fatalRptEn(fatalRptEn),
    .nonFatalRptEn(nonFatalRptEn), .ueMask(ueMask), .ueSev(ueSev),
    .ptrFree(ptrFree), .ptrValid(logPtrValid),
    .perrOut(perrOut), .poisonOut(poisonOut),
    .msgFatal(msgFatal), .msgNonFatal(msgNonFatal)
  );
endmodule

// File: rtl/xerr_checker.sv
module xerr_checker (
  input logic clk,
  input logic rstN,
  input logic splitDataErr,
  input logic masterPerr,
  input logic cplPoisoned,
  input logic perrRespEn,
  input logic logPtrValid,
  input logic perrOut,
  input logic poisonOut,
  input logic msgFatal,
  input logic msgNonFatal
);
  // R2
  poison_follows_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    splitDataErr |=> poisonOut);

  // R2
  poison_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    poisonOut |-> $past(splitDataErr));

  // R3
  perr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    perrOut |-> $past(splitDataErr && perrRespEn));

  // R10
  msg_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(msgFatal && msgNonFatal));

  // R5
  ptr_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(logPtrValid) |-> $past(splitDataErr || (masterPerr && !cplPoisoned)));
endmodule

bind xerr_reporter xerr_checker u_chk (
  .clk(clk), .rstN(rstN), .splitDataErr(splitDataErr), .masterPerr(masterPerr),
  .cplPoisoned(cplPoisoned), .perrRespEn(perrRespEn), .logPtrValid(logPtrValid),
  .perrOut(perrOut), .poisonOut(poisonOut), .msgFatal(msgFatal),
  .msgNonFatal(msgNonFatal)
);

// File: tb/xerr_reporter_bench.sv
module xerr_reporter_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         splitDataErr = 1'b0;
  logic         masterPerr = 1'b0;
  logic         cplPoisoned = 1'b0;
  logic [127:0] evtHdr = '0;
  logic         cfgWe = 1'b0;
  logic [3:0]   cfgAddr = '0;
  logic [31:0]  cfgWdata = '0;
  logic [31:0]  cfgRdata;
  logic         perrOut, poisonOut, msgFatal, msgNonFatal;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic [3:0] pins;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xerr_reporter u_xerr_reporter (
    .clk(clk), .rstN(rstN), .splitDataErr(splitDataErr), .masterPerr(masterPerr),
    .cplPoisoned(cplPoisoned), .evtHdr(evtHdr), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .perrOut(perrOut),
    .poisonOut(poisonOut), .msgFatal(msgFatal), .msgNonFatal(msgNonFatal)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pins {perr, poison, msgFatal, msgNonFatal} each low phase
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [3:0] expPins;
      string      tag;
      expPins = 4'b0000;
      tag = "R2 R3 R6 idle";
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        expPins = sbq[0].pins;
        tag = sbq[0].tag;
        void'(sbq.pop_front());
      end
      check(tag, {28'd0, perrOut, poisonOut, msgFatal, msgNonFatal}, {28'd0, expPins});
    end
  end

  task automatic cfgWrite(logic [3:0] addr, logic [31:0] data);
    cfgWe = 1'b1; cfgAddr = addr; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0; cfgWdata = '0;
  endtask

  task automatic readChk(logic [3:0] addr, logic [31:0] exp, string tag);
    cfgAddr = addr;
    #1;
    check(tag, cfgRdata, exp);
  endtask

  task automatic fire(logic sp, logic mp, logic pois, logic [127:0] hdr,
                      logic [3:0] pins, string tag);
    exp_t e;
    splitDataErr = sp; masterPerr = mp; cplPoisoned = pois; evtHdr = hdr;
    e.due = cyc + 1; e.pins = pins; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    splitDataErr = 1'b0; masterPerr = 1'b0; cplPoisoned = 1'b0; evtHdr = '0;
  endtask

  task automatic hdrChk(logic [127:0] hdr, string tag);
    for (int w = 0; w < 4; w++) readChk(4'(8 + w), hdr[w*32 +: 32], tag);
  endtask

  localparam logic [127:0] HDR_A = 128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0;
  localparam logic [127:0] HDR_B = 128'hB0000004_B0000003_B0000002_B0000001;
  localparam logic [127:0] HDR_C = 128'hC0C0C0C0_C1C1C1C1_C2C2C2C2_C3C3C3C3;
  localparam logic [127:0] HDR_D = 128'hD000000D_D000000C_D000000B_D000000A;
  localparam logic [127:0] HDR_E = 128'hE0E0E0E0_E0E0E0E1_E0E0E0E2_E0E0E0E3;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readChk(4'd0, 32'h0, "R1 ctrl");
    readChk(4'd3, 32'h0, "R1 uests");
    readChk(4'd6, 32'h0, "R1 ptr");
    readChk(4'd8, 32'h0, "R1 hdr0");
    check("R1 pins", {28'd0, perrOut, poisonOut, msgFatal, msgNonFatal}, 32'h0);

    // R2 poison without enables; R3 no perr; R6 no message
    fire(1, 0, 0, HDR_A, 4'b0100, "R2 R3 R6 split no enables");
    readChk(4'd3, 32'h1, "R4 split status");
    readChk(4'd1, 32'h0, "R3 mdpe clear");
    readChk(4'd2, 32'h2, "R8 nonfatal seen");
    readChk(4'd6, 32'h8000_0000, "R5 ptr idx0");
    hdrChk(HDR_A, "R5 header A");

    // R5 pointer valid blocks overwrite; R2 master parity never poisons
    fire(0, 1, 0, HDR_B, 4'b0000, "R2 mperr no poison");
    readChk(4'd3, 32'h3, "R4 mperr status");
    hdrChk(HDR_A, "R5 log kept");

    // R9 clearing a non-pointed bit keeps pointer, pointed bit frees it
    cfgWrite(4'd3, 32'h2);
    readChk(4'd3, 32'h1, "R9 w1c bit1");
    readChk(4'd6, 32'h8000_0000, "R9 ptr kept");
    cfgWrite(4'd3, 32'h1);
    readChk(4'd3, 32'h0, "R9 w1c bit0");
    readChk(4'd6, 32'h0, "R9 ptr invalid");

    // R3 + R6 non-fatal enable path; R11 control readback
    cfgWrite(4'd0, 32'h9);
    readChk(4'd0, 32'h9, "R11 ctrl rw");
    fire(1, 0, 0, HDR_B, 4'b1101, "R3 R6 perr nonfatal msg");
    readChk(4'd1, 32'h1, "R3 mdpe set R7 no sse");
    hdrChk(HDR_B, "R9 rearmed log");

    // R4 mask does not stop status; R5 mask blocks log; R6 mask blocks msg
    cfgWrite(4'd4, 32'h1);
    readChk(4'd4, 32'h1, "R11 mask rw");
    cfgWrite(4'd3, 32'h3);
    cfgWrite(4'd1, 32'h3);
    cfgWrite(4'd2, 32'h3);
    readChk(4'd6, 32'h0, "R9 ptr freed");
    fire(1, 0, 0, HDR_C, 4'b1100, "R6 masked no msg");
    readChk(4'd3, 32'h1, "R4 masked status");
    readChk(4'd6, 32'h0, "R5 masked no ptr");
    hdrChk(HDR_B, "R5 masked log kept");

    // R4 poisoned completion parity event ignored
    fire(0, 1, 1, HDR_C, 4'b0000, "R4 poisoned ignored");
    readChk(4'd3, 32'h1, "R4 poisoned no status");

    // R6 R7 R8 system error path with fatal severity
    cfgWrite(4'd4, 32'h0);
    cfgWrite(4'd3, 32'h3);
    cfgWrite(4'd1, 32'h3);
    cfgWrite(4'd2, 32'h3);
    cfgWrite(4'd0, 32'h2);
    cfgWrite(4'd5, 32'h2);
    readChk(4'd5, 32'h2, "R11 sev rw");
    fire(0, 1, 0, HDR_D, 4'b0010, "R6 fatal via syserr");
    readChk(4'd1, 32'h2, "R7 sse set");
    readChk(4'd2, 32'h1, "R8 fatal seen");
    readChk(4'd6, 32'h8000_0001, "R5 ptr idx1");
    hdrChk(HDR_D, "R5 header D");

    // R10 simultaneous errors
    cfgWrite(4'd3, 32'h3);
    cfgWrite(4'd1, 32'h3);
    cfgWrite(4'd2, 32'h3);
    fire(1, 1, 0, HDR_E, 4'b0110, "R10 fatal beats nonfatal");
    readChk(4'd6, 32'h8000_0000, "R10 lower bit wins ptr");
    readChk(4'd2, 32'h3, "R8 both seen");
    readChk(4'd3, 32'h3, "R4 both status");

    // R6 R7 class enable only, no syserr
    cfgWrite(4'd3, 32'h3);
    cfgWrite(4'd1, 32'h3);
    cfgWrite(4'd0, 32'h4);
    fire(0, 1, 0, HDR_A, 4'b0010, "R6 fatal enable path");
    readChk(4'd1, 32'h0, "R7 no sse without syserr");
    fire(1, 0, 0, HDR_A, 4'b0100, "R6 nonfatal class disabled");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule